// File: doc/BRIEF.md
# Timer PWM Channel Generator

This block is a 16-bit up-counting timer with a clock prescaler and a single pulse-width-modulated output channel. Software-side logic programs it through a plain write port (enable, address, data): a control word, a prescaler value, a period (reload) value and a duty (compare) value. The prescaler slows the counter so that long periods still fit in 16 bits. The counter runs from 0 to the reload value and wraps to 0. The compare value, judged against the counter, sets the duty cycle. Two compare-mode codes select opposite output polarities.

The period and the prescaler values are always double-buffered. The compare value is double-buffered when the preload bit is set. Written values wait in shadow registers and move into the active registers only at the update event, which is the wrap from the reload value back to 0. Because of this, a new duty value or period never cuts a running period short and never makes a runt pulse. While the counter is stopped, the shadows load straight through so the timer can be set up before it is started.

A two-state run controller sets the operating phase. In IDLE the counter and prescaler hold their values and the active registers follow the shadows. In RUN the counter advances on each prescaler tick. The transition IDLE to RUN (start) is taken on the first clock after the counter-enable bit reads 1. The transition RUN to IDLE (stop) is taken on the first clock after it reads 0.

Top module: `pwm_timer_channel`

## Requirements
- R1: Writes decode by address: 0 is control (bit 0 counter enable, bit 1 output enable, bit 2 compare preload enable, bits 6:4 compare mode), 1 is prescaler, 2 is reload, 3 is compare. A write to any other address changes nothing.
- R2: While running, the counter steps by one on each prescaler tick up to the active reload value. The tick after that wraps it to 0. `upd_evt` is high for exactly the cycle in which the counter first shows 0 after a wrap. A counter found above the reload value also wraps on its next tick.
- R3: With an active prescaler value P, the counter advances once every P+1 clock cycles, giving a period of (reload+1)*(P+1) cycles.
- R4: Mode code 3'b110 drives the output high while counter < active compare and low otherwise. Code 3'b111 drives the inverse. Every other code holds the output low.
- R5: While the output-enable bit is 0, the output is low.
- R6: The counter runs only while the counter-enable bit is 1. Once the run controller has left RUN, the counter and prescaler hold their values.
- R7: With the preload bit set and the timer running, a compare write goes to the shadow only. The output keeps using the old compare value until the next update event.
- R8: With the preload bit clear, a compare write is used by the output from the cycle after the write.
- R9: While running, prescaler and reload writes take effect only at the update event. While stopped, they take effect from the cycle after the write.
- R10: In mode 3'b110, a compare value above the reload value gives a constantly high output, and a compare value of 0 gives a constantly low output.
- R11: A shadowed write captured on the same clock edge as the update event is included in that update.
- R12: After reset the counter is 0, the output is low, `upd_evt` is low, control is 0, prescaler and compare are 0, and reload is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register address |
| wr_data | input | CNT_W (16) | Register write data |
| pwm_out | output | 1 | PWM channel output |
| cnt_out | output | CNT_W (16) | Current counter value |
| upd_evt | output | 1 | High in the cycle after a wrap (update event) |

## Verification
The risky coincidence is a shadowed register write captured on the same clock edge as the counter wrap. In that case the shadow load and the update event compete for the same edge. The bench lets the counter run from one wrap, counts exactly reload cycles, and then puts a preloaded compare write on the wrap edge. It judges the result by checking every output sample of the following period against the newly written duty. A second scenario places the write one cycle after a wrap, to show that a write outside the update edge waits a whole period.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    // control word field positions
    localparam int CTL_CEN      = 0;
    localparam int CTL_OE       = 1;
    localparam int CTL_PE       = 2;
    localparam int CTL_MODE_LSB = 4;
    localparam int MODE_W       = 3;

    // register addresses
    localparam int ADR_CTRL = 0;
    localparam int ADR_PSC  = 1;
    localparam int ADR_ARR  = 2;
    localparam int ADR_CMP  = 3;

    // compare mode codes
    localparam logic [MODE_W-1:0] MODE_PWM_HI = 3'b110;
    localparam logic [MODE_W-1:0] MODE_PWM_LO = 3'b111;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CNT_W-1:0]    wr_data,
    output logic                cen,
    output logic                oe,
    output logic                pe,
    output logic [MODE_W-1:0]   mode,
    output logic [CNT_W-1:0]    psc_nxt,
    output logic [CNT_W-1:0]    arr_nxt,
    output logic [CNT_W-1:0]    cmp_nxt
);

    logic               sel_ctrl, sel_psc, sel_arr, sel_cmp;
    logic [CNT_W-1:0]   psc_sh, arr_sh, cmp_sh;

    // address decode
    always_comb begin
        sel_ctrl = 1'b0;
        sel_psc  = 1'b0;
        sel_arr  = 1'b0;
        sel_cmp  = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                ADDR_W'(ADR_CTRL): sel_ctrl = 1'b1;
                ADDR_W'(ADR_PSC):  sel_psc  = 1'b1;
                ADDR_W'(ADR_ARR):  sel_arr  = 1'b1;
                ADDR_W'(ADR_CMP):  sel_cmp  = 1'b1;
                default: ;
            endcase
        end
    end

    // control and shadow registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cen    <= 1'b0;
            oe     <= 1'b0;
            pe     <= 1'b0;
            mode   <= '0;
            psc_sh <= '0;
            arr_sh <= '1;
            cmp_sh <= '0;
        end else begin
            if (sel_ctrl) begin
                cen  <= wr_data[CTL_CEN];
                oe   <= wr_data[CTL_OE];
                pe   <= wr_data[CTL_PE];
                mode <= wr_data[CTL_MODE_LSB +: MODE_W];
            end
            if (sel_psc) psc_sh <= wr_data;
            if (sel_arr) arr_sh <= wr_data;
            if (sel_cmp) cmp_sh <= wr_data;
        end
    end

    // forwarded shadow values: a write in flight is seen by any load on the same edge
    assign psc_nxt = sel_psc ? wr_data : psc_sh;
    assign arr_nxt = sel_arr ? wr_data : arr_sh;
    assign cmp_nxt = sel_cmp ? wr_data : cmp_sh;

    AST_IGNORED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr > ADDR_W'(ADR_CMP))) |=>
            ($stable({cen, oe, pe, mode}) && $stable(psc_sh) && $stable(arr_sh) && $stable(cmp_sh))); // R1

endmodule

// File: rtl/pwm_tmr_prescaler.sv
module pwm_tmr_prescaler #(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CNT_W-1:0]  psc_act,
    output logic              tick
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] div_q;

    assign tick = run && (div_q >= psc_act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= div_q + ONE;
        end
    end

    AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(div_q)); // R6

    AST_DIV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (div_q == $past(div_q) + ONE)); // R3

endmodule

// File: rtl/pwm_tmr_counter.sv
module pwm_tmr_counter
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen,
    input  logic              tick,
    input  logic [CNT_W-1:0]  psc_nxt,
    input  logic [CNT_W-1:0]  arr_nxt,
    output logic              run,
    output logic              idle,
    output logic              upd_load,
    output logic              upd_evt,
    output logic [CNT_W-1:0]  psc_act,
    output logic [CNT_W-1:0]  cnt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    run_state_t        state_q, state_d;
    logic [CNT_W-1:0]  arr_act;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: start (IDLE->RUN), stop (RUN->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cen)  state_d = ST_RUN;
            ST_RUN:  if (!cen) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        run  = 1'b0;
        idle = 1'b0;
        unique case (state_q)
            ST_IDLE: idle = 1'b1;
            ST_RUN:  run  = 1'b1;
            default: idle = 1'b1;
        endcase
    end

    assign upd_load = run && tick && (cnt >= arr_act);

    // counter, update flag and active period/prescaler registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            upd_evt <= 1'b0;
            arr_act <= '1;
            psc_act <= '0;
        end else begin
            upd_evt <= upd_load;
            if (upd_load)              cnt <= '0;
            else if (run && tick)      cnt <= cnt + ONE;
            if (idle || upd_load) begin
                arr_act <= arr_nxt;
                psc_act <= psc_nxt;
            end
        end
    end

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt |-> (cnt == '0)); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && (cnt < arr_act)) |=> (cnt == $past(cnt) + ONE)); // R2

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> $stable(cnt)); // R6

    AST_RELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !upd_load) |=> ($stable(arr_act) && $stable(psc_act))); // R9

endmodule

// File: rtl/pwm_tmr_compare.sv
module pwm_tmr_compare
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idle,
    input  logic               upd_load,
    input  logic               pe,
    input  logic               oe,
    input  logic [MODE_W-1:0]  mode,
    input  logic [CNT_W-1:0]   cmp_nxt,
    input  logic [CNT_W-1:0]   cnt,
    output logic               pwm
);

    logic [CNT_W-1:0] cmp_act;
    logic             below;

    // active compare: direct when not preloaded or stopped, else at update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cmp_act <= '0;
        else if (idle || !pe || upd_load) cmp_act <= cmp_nxt;
    end

    assign below = cnt < cmp_act;

    always_comb begin
        pwm = 1'b0;
        if (oe) begin
            case (mode)
                MODE_PWM_HI: pwm = below;
                MODE_PWM_LO: pwm = !below;
                default:     pwm = 1'b0;
            endcase
        end
    end

    AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !pwm); // R5

    AST_BAD_MODE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode != MODE_PWM_HI) && (mode != MODE_PWM_LO)) |-> !pwm); // R4

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pe && !idle && !upd_load) |=> $stable(cmp_act)); // R7

    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !pe |=> (cmp_act == $past(cmp_nxt))); // R8

endmodule

// File: rtl/pwm_timer_channel.sv
module pwm_timer_channel
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    output logic               pwm_out,
    output logic [CNT_W-1:0]   cnt_out,
    output logic               upd_evt
);

    logic               cen, oe, pe;
    logic [MODE_W-1:0]  mode;
    logic [CNT_W-1:0]   psc_nxt, arr_nxt, cmp_nxt, psc_act;
    logic               run, idle, tick, upd_load;

    pwm_tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cen     (cen),
        .oe      (oe),
        .pe      (pe),
        .mode    (mode),
        .psc_nxt (psc_nxt),
        .arr_nxt (arr_nxt),
        .cmp_nxt (cmp_nxt)
    );

    pwm_tmr_prescaler #(.CNT_W(CNT_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .psc_act (psc_act),
        .tick    (tick)
    );

    pwm_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cen      (cen),
        .tick     (tick),
        .psc_nxt  (psc_nxt),
        .arr_nxt  (arr_nxt),
        .run      (run),
        .idle     (idle),
        .upd_load (upd_load),
        .upd_evt  (upd_evt),
        .psc_act  (psc_act),
        .cnt      (cnt_out)
    );

    pwm_tmr_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle     (idle),
        .upd_load (upd_load),
        .pe       (pe),
        .oe       (oe),
        .mode     (mode),
        .cmp_nxt  (cmp_nxt),
        .cnt      (cnt_out),
        .pwm      (pwm_out)
    );

endmodule

// File: tb/pwm_timer_channel_test.sv
module pwm_timer_channel_test;

    localparam int CLK_NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_out;
    logic [15:0] cnt_out;
    logic        upd_evt;

    int total_n = 0;
    int failed_n = 0;

    pwm_timer_channel uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .cnt_out(cnt_out), .upd_evt(upd_evt)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total_n++;
        if (!ok) begin
            failed_n++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic do_write(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic sync_upd(input string req);
        int guard = 0;
        while (!upd_evt && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk(upd_evt, req, "update event seen", int'(upd_evt), 1);
    endtask

    // starts at a negedge with cnt==0 after a wrap; ends at the next such negedge
    task automatic check_period(input int arr, input int cmpv, input logic [2:0] mode,
                                input bit oe_on, input string req);
        for (int k = 0; k <= arr; k++) begin
            bit below = (k < cmpv);
            bit e = 1'b0;
            if (oe_on && mode == 3'b110) e = below;
            else if (oe_on && mode == 3'b111) e = !below;
            chk(int'(cnt_out) == k, "R2", "counter value", int'(cnt_out), k);
            chk(pwm_out == e, req, "pwm level", int'(pwm_out), int'(e));
            @(negedge clk);
        end
        chk(upd_evt == 1'b1 && cnt_out == 16'd0, "R2", "wrap to zero with update",
            int'(cnt_out), 0);
    endtask

    task automatic t_reset;
        chk(cnt_out == 16'd0, "R12", "reset counter", int'(cnt_out), 0);
        chk(pwm_out == 1'b0, "R12", "reset pwm", int'(pwm_out), 0);
        chk(upd_evt == 1'b0, "R12", "reset update flag", int'(upd_evt), 0);
    endtask

    task automatic t_basic;
        do_write(3'd2, 16'd9);
        do_write(3'd3, 16'd4);
        do_write(3'd0, 16'h0063);
        sync_upd("R6");
        check_period(9, 4, 3'b110, 1'b1, "R4");
        check_period(9, 4, 3'b110, 1'b1, "R4");
    endtask

    task automatic t_mode2;
        do_write(3'd0, 16'h0073);
        sync_upd("R2");
        check_period(9, 4, 3'b111, 1'b1, "R4");
    endtask

    task automatic t_badmode;
        do_write(3'd0, 16'h0053);
        sync_upd("R2");
        check_period(9, 4, 3'b101, 1'b1, "R4");
    endtask

    task automatic t_oe_off;
        do_write(3'd0, 16'h0061);
        sync_upd("R2");
        check_period(9, 4, 3'b110, 1'b0, "R5");
    endtask

    task automatic t_direct;
        do_write(3'd0, 16'h0063);
        sync_upd("R2");
        repeat (2) @(negedge clk);
        do_write(3'd3, 16'd7);
        chk(pwm_out == (cnt_out < 16'd7), "R8", "compare used next cycle",
            int'(pwm_out), int'(cnt_out < 16'd7));
        sync_upd("R2");
        check_period(9, 7, 3'b110, 1'b1, "R8");
    endtask

    task automatic t_preload;
        do_write(3'd0, 16'h0067);
        sync_upd("R2");
        chk(pwm_out == 1'b1, "R7", "old duty at period start", int'(pwm_out), 1);
        do_write(3'd3, 16'd2);
        for (int k = 1; k <= 9; k++) begin
            chk(pwm_out == (k < 7), "R7", "old duty kept until update",
                int'(pwm_out), int'(k < 7));
            @(negedge clk);
        end
        check_period(9, 2, 3'b110, 1'b1, "R7");
    endtask

    task automatic t_coincide;
        // synced at cnt==0; wrap edge is the 10th edge from here
        repeat (9) @(negedge clk);
        do_write(3'd3, 16'd3);
        chk(upd_evt == 1'b1, "R11", "write landed on update edge", int'(upd_evt), 1);
        check_period(9, 3, 3'b110, 1'b1, "R11");
    endtask

    task automatic t_ignore;
        do_write(3'd5, 16'h0000);
        do_write(3'd6, 16'h0000);
        do_write(3'd7, 16'h0000);
        sync_upd("R1");
        check_period(9, 3, 3'b110, 1'b1, "R1");
    endtask

    task automatic t_bounds;
        do_write(3'd0, 16'h0063);
        do_write(3'd3, 16'd12);
        sync_upd("R2");
        check_period(9, 12, 3'b110, 1'b1, "R10");
        do_write(3'd3, 16'd0);
        sync_upd("R2");
        check_period(9, 0, 3'b110, 1'b1, "R10");
    endtask

    task automatic t_psc;
        int n;
        sync_upd("R2");
        do_write(3'd1, 16'd2);
        do_write(3'd2, 16'd5);
        n = 2;
        while (!upd_evt && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n == 10, "R9", "old period kept until update", n, 10);
        for (int j = 1; j <= 18; j++) begin
            @(negedge clk);
            chk(int'(cnt_out) == (j / 3) % 6, "R3", "prescaled count", int'(cnt_out), (j / 3) % 6);
            chk(upd_evt == (j == 18), "R3", "update spacing", int'(upd_evt), int'(j == 18));
        end
    endtask

    task automatic t_stop;
        logic [15:0] held;
        int n;
        do_write(3'd0, 16'h0062);
        repeat (3) @(negedge clk);
        held = cnt_out;
        repeat (5) @(negedge clk);
        chk(cnt_out == held, "R6", "counter holds when disabled", int'(cnt_out), int'(held));
        do_write(3'd1, 16'd0);
        do_write(3'd2, 16'd3);
        do_write(3'd0, 16'h0063);
        sync_upd("R2");
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!upd_evt && n < 100);
        chk(n == 4, "R9", "stopped-time writes load directly", n, 4);
        chk(pwm_out == 1'b0, "R10", "zero compare gives low", int'(pwm_out), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_mode2();
        t_badmode();
        t_oe_off();
        t_direct();
        t_preload();
        t_coincide();
        t_ignore();
        t_bounds();
        t_psc();
        t_stop();
        $display("%0d/%0d checks passed", total_n - failed_n, total_n);
        $finish;
    end

    initial begin
        #(CLK_NS * 100000);
        total_n++;
        failed_n++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", total_n - failed_n, total_n);
        $finish;
    end

endmodule